// File: doc/BRIEF.md
# Narrow Burst Write Address and Strobe Generator

This block is the master-side sequencer for write bursts on a 32-bit AHB-style bus. The beat size can be narrower than the bus. A request gives a start address, a beat size, a burst type and the lane-ordering mode. From that request the block drives the address, the transfer code, the size, the burst type and the byte-lane write strobe for every beat. Each beat's strobe is derived from that beat's own address, not from the start address. A beat is accepted on a clock edge where it is driven and `hready_i` is high. While `hready_i` is low, the block holds the current beat unchanged.

Incrementing bursts step by the beat size. Wrapping bursts stay inside an aligned block whose size is the beat count times the beat size, and fold back to the start of that block. For example, a 16-beat halfword wrap from 0x30 runs 0x30..0x3E and then 0x20..0x2E. Lane selection has two mappings. Little-endian and byte-invariant big-endian use the natural lane order. Word-invariant big-endian mirrors the lanes within the word. When the burst ends, the block returns to idle and pulses a completion flag.

Top module: `nbw_burst_gen`

## Requirements
- R1: During and after reset with no request, `htrans_o` is IDLE (2'b00), `hwstrb_o` is 0, and `busy_o` and `done_o` are 0.
- R2: `start_i` is taken only while `busy_o` is low. In the next cycle the first beat is driven with NONSEQ (2'b10) at `start_addr_i`, with the address bits below the beat size cleared. A `start_i` pulse raised while `busy_o` is high has no effect on the running burst.
- R3: Every beat after the first is driven with SEQ (2'b11). In an incrementing burst, each accepted beat advances the address by 2^size bytes.
- R4: `burst_i` codes give the beat count: 0 is single (1 beat), 1 is incrementing with `len_i`+1 beats, 3/5/7 are incrementing with 4/8/16 beats, and 2/4/6 are wrapping with 4/8/16 beats.
- R5: A wrapping burst keeps every address inside the aligned block of (beats × 2^size) bytes that holds the start address. The step after the block's last address goes to the block's first address.
- R6: While a beat is driven and `hready_i` is low, the address, transfer code and strobe stay unchanged in the next cycle.
- R7: With `wi_mode_i`=0, strobe bit n enables byte lane n (data bits 8n+7:8n). A byte beat sets bit `haddr[1:0]`. A halfword beat sets 4'b0011 when `haddr[1]`=0 and 4'b1100 when `haddr[1]`=1. A word beat sets 4'b1111.
- R8: With `wi_mode_i`=1 (word-invariant big-endian), the strobe is the R7 strobe with lane n moved to lane 3−n. For example, a halfword at `haddr[1]`=0 gives 4'b1100. The mode is captured when the burst starts.
- R9: In the cycle after the last beat is accepted, `htrans_o` is IDLE, `hwstrb_o` is 0, `busy_o` is low, and `done_o` is high for exactly that one cycle.
- R10: `size_i` is 0 for byte, 1 for halfword and 2 for word. Larger codes are treated as word. During a burst, `hsize_o` and `hburst_o` show the captured (clamped) size and the burst code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new burst (taken when idle) |
| start_addr_i | input | 32 | Burst start address |
| size_i | input | 3 | Beat size code |
| burst_i | input | 3 | Burst type code |
| len_i | input | 4 | Beats minus one for the open incrementing type |
| wi_mode_i | input | 1 | 1 selects word-invariant big-endian lane mapping |
| hready_i | input | 1 | Bus ready; a driven beat is accepted when high |
| haddr_o | output | 32 | Current beat address |
| htrans_o | output | 2 | Transfer code: IDLE, NONSEQ or SEQ |
| hsize_o | output | 3 | Captured beat size |
| hburst_o | output | 3 | Captured burst type |
| hwstrb_o | output | 4 | Byte-lane write strobe for the current beat |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse after the last beat is accepted |

## Verification
The bench drives every beat size with both lane mappings. This separates the natural lane order from the mirrored one and tests both values of address bit 1 for halfwords. It runs wrapping bursts of 4, 8 and 16 beats from starts in the middle of their blocks, including the halfword wrap from 0x30. These show the fold point apart from plain incrementing. Other runs cover irregular ready stalls, unaligned start addresses, an oversize size code, a request raised in the middle of a burst, and a new request issued in the completion cycle. These show that holding, alignment, size clamping, ignoring a busy-time request and back-to-back start-up each behave as required.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    BT_SINGLE = 3'd0,
    BT_INCR   = 3'd1,
    BT_WRAP4  = 3'd2,
    BT_INCR4  = 3'd3,
    BT_WRAP8  = 3'd4,
    BT_INCR8  = 3'd5,
    BT_WRAP16 = 3'd6,
    BT_INCR16 = 3'd7
  } burst_e;
endpackage

// File: rtl/nbw_addr_step.sv
module nbw_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic              wrap_i,
  input  logic [2:0]        wrap_log_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] inc, sum, blk_mask;
  logic [3:0]        blk_log;

  always_comb begin
    inc      = ADDR_W'(1) << size_i;
    sum      = addr_i + inc;
    blk_log  = {1'b0, wrap_log_i} + {1'b0, size_i};
    blk_mask = (ADDR_W'(1) << blk_log) - ADDR_W'(1);
    // wrap keeps upper bits, lets only the in-block offset roll over
    next_o   = wrap_i ? ((addr_i & ~blk_mask) | (sum & blk_mask)) : sum;
  end
endmodule

// File: rtl/nbw_lane_strobe.sv
module nbw_lane_strobe #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [2:0]                  size_i,
  input  logic                        wi_i,
  output logic [DATA_W/8-1:0]         strb_o
);
  localparam int LANES    = DATA_W / 8;
  localparam int LANE_LOG = $clog2(LANES);

  logic [2*LANES-1:0]  ones_w, le_w;
  logic [LANE_LOG-1:0] off_al, sz_mask;
  logic [LANES-1:0]    le;

  always_comb begin
    sz_mask = LANE_LOG'((LANES'(1) << size_i) - LANES'(1));
    off_al  = off_i & ~sz_mask;
    ones_w  = ((2*LANES)'(1) << (LANES'(1) << size_i)) - (2*LANES)'(1);
    le_w    = ones_w << off_al;
    le      = le_w[LANES-1:0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb_o[g] = wi_i ? le[LANES-1-g] : le[g];
  end
endmodule

// File: rtl/nbw_beat_ctrl.sv
module nbw_beat_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] beats_m1_i,
  input  logic             hready_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             active_o,
  output logic             first_o,
  output logic             done_o
);
  logic             active_q, first_q, done_q;
  logic [CNT_W-1:0] remain_q;
  logic             take, last;

  assign load_o   = start_i & ~active_q;
  assign take     = active_q & hready_i;
  assign last     = (remain_q == '0);
  assign adv_o    = take & ~last;
  assign active_o = active_q;
  assign first_o  = first_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      done_q   <= 1'b0;
      remain_q <= '0;
    end else if (load_o) begin
      active_q <= 1'b1;
      first_q  <= 1'b1;
      done_q   <= 1'b0;
      remain_q <= beats_m1_i;
    end else if (take) begin
      first_q <= 1'b0;
      if (last) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        remain_q <= remain_q - CNT_W'(1);
        done_q   <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nbw_burst_gen.sv
module nbw_burst_gen
  import nbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   start_addr_i,
  input  logic [2:0]          size_i,
  input  logic [2:0]          burst_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                wi_mode_i,
  input  logic                hready_i,
  output logic [ADDR_W-1:0]   haddr_o,
  output logic [1:0]          htrans_o,
  output logic [2:0]          hsize_o,
  output logic [2:0]          hburst_o,
  output logic [DATA_W/8-1:0] hwstrb_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int LANES    = DATA_W / 8;
  localparam int LANE_LOG = $clog2(LANES);
  localparam int CNT_W    = (LEN_W > 4) ? LEN_W : 4;

  logic [2:0]        size_c;
  logic [CNT_W-1:0]  beats_m1;
  logic [ADDR_W-1:0] addr_al, addr_q, addr_nxt;
  logic [2:0]        size_q, burst_q, wrap_log;
  logic              wi_q, wrap_q;
  logic              load, adv, active, first;
  logic [LANES-1:0]  strb;

  // oversize codes fall back to full bus width
  assign size_c  = (size_i > 3'(LANE_LOG)) ? 3'(LANE_LOG) : size_i;
  assign addr_al = start_addr_i & ~((ADDR_W'(1) << size_c) - ADDR_W'(1));

  always_comb begin
    unique case (burst_e'(burst_i))
      BT_SINGLE:           beats_m1 = CNT_W'(0);
      BT_INCR:             beats_m1 = CNT_W'(len_i);
      BT_WRAP4, BT_INCR4:  beats_m1 = CNT_W'(3);
      BT_WRAP8, BT_INCR8:  beats_m1 = CNT_W'(7);
      default:             beats_m1 = CNT_W'(15);
    endcase
  end

  always_comb begin
    wrap_q = (burst_q == BT_WRAP4) || (burst_q == BT_WRAP8) || (burst_q == BT_WRAP16);
    unique case (burst_e'(burst_q))
      BT_WRAP4: wrap_log = 3'd2;
      BT_WRAP8: wrap_log = 3'd3;
      default:  wrap_log = 3'd4;
    endcase
  end

  nbw_beat_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .beats_m1_i (beats_m1),
    .hready_i   (hready_i),
    .load_o     (load),
    .adv_o      (adv),
    .active_o   (active),
    .first_o    (first),
    .done_o     (done_o)
  );

  nbw_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i     (addr_q),
    .size_i     (size_q),
    .wrap_i     (wrap_q),
    .wrap_log_i (wrap_log),
    .next_o     (addr_nxt)
  );

  nbw_lane_strobe #(.DATA_W(DATA_W)) u_lane (
    .off_i  (addr_q[LANE_LOG-1:0]),
    .size_i (size_q),
    .wi_i   (wi_q),
    .strb_o (strb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      size_q  <= '0;
      burst_q <= '0;
      wi_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= addr_al;
      size_q  <= size_c;
      burst_q <= burst_i;
      wi_q    <= wi_mode_i;
    end else if (adv) begin
      addr_q  <= addr_nxt;
    end
  end

  assign haddr_o  = addr_q;
  assign htrans_o = !active ? TR_IDLE : (first ? TR_NONSEQ : TR_SEQ);
  assign hsize_o  = size_q;
  assign hburst_o = burst_q;
  assign hwstrb_o = active ? strb : '0;
  assign busy_o   = active;
endmodule

// File: rtl/nbw_burst_gen_chk.sv
module nbw_burst_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hready_i,
  input logic [ADDR_W-1:0] haddr_o,
  input logic [1:0]        htrans_o,
  input logic [2:0]        hsize_o,
  input logic [LANES-1:0]  hwstrb_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r2_first_nonseq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> htrans_o == 2'b10);

  a_r3_seq_follows_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_o == 2'b11 |-> $past(htrans_o) != 2'b00);

  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o != 2'b00 && !hready_i) |=>
      ($stable(haddr_o) && $stable(hwstrb_o) && $stable(htrans_o)));

  a_r7_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o != 2'b00 && hsize_o == 3'd0) |-> $countones(hwstrb_o) == 1);

  a_r7_half_two_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o != 2'b00 && hsize_o == 3'd1) |-> $countones(hwstrb_o) == 2);

  a_r9_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_o == 2'b00 |-> hwstrb_o == '0);

  a_r9_done_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(htrans_o) != 2'b00 && $past(hready_i) && !busy_o));
endmodule

bind nbw_burst_gen nbw_burst_gen_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hready_i (hready_i),
  .haddr_o  (haddr_o),
  .htrans_o (htrans_o),
  .hsize_o  (hsize_o),
  .hwstrb_o (hwstrb_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/nbw_burst_gen_bench.sv
`timescale 1ns/1ps
module nbw_burst_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] in_addr = '0;
  logic [2:0]  in_size = '0;
  logic [2:0]  in_burst = '0;
  logic [3:0]  in_len = '0;
  logic        in_wi = 1'b0;
  logic        hready_i = 1'b1;
  logic [31:0] haddr_o;
  logic [1:0]  htrans_o;
  logic [2:0]  hsize_o, hburst_o;
  logic [3:0]  hwstrb_o;
  logic        busy_o, done_o;

  always #2 clk = ~clk;

  nbw_burst_gen u_nbw_burst_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(in_addr),
    .size_i(in_size), .burst_i(in_burst), .len_i(in_len), .wi_mode_i(in_wi),
    .hready_i(hready_i), .haddr_o(haddr_o), .htrans_o(htrans_o),
    .hsize_o(hsize_o), .hburst_o(hburst_o), .hwstrb_o(hwstrb_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit m_active = 0, m_first = 0, m_done = 0, m_wi = 0, m_wrap = 0, prev_stall = 0;
  int m_size = 0, m_burst = 0, m_beats = 0, obs_beats = 0;

  task automatic check(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int beats_of(int b, int len);
    case (b)
      0: return 1;
      1: return len + 1;
      2, 3: return 4;
      4, 5: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [3:0] lanes_of(int a, int sz, bit wi);
    logic [3:0] s;
    if (sz == 0) s = 4'b0001 << (a % 4);
    else if (sz == 1) s = ((a / 2) % 2 == 1) ? 4'b1100 : 4'b0011;
    else s = 4'b1111;
    if (wi) s = {s[0], s[1], s[2], s[3]};
    return s;
  endfunction

  task automatic load_model();
    int inc, a0, blk, base;
    m_size  = (in_size > 2) ? 2 : int'(in_size);
    inc     = 1 << m_size;
    a0      = int'(in_addr) & ~(inc - 1);
    m_burst = int'(in_burst);
    m_beats = beats_of(m_burst, int'(in_len));
    m_wrap  = (m_burst == 2 || m_burst == 4 || m_burst == 6);
    m_wi    = in_wi;
    blk     = m_beats * inc;
    base    = (a0 / blk) * blk;
    exp_q.delete();
    for (int i = 0; i < m_beats; i++)
      exp_q.push_back(m_wrap ? base + ((a0 - base + i * inc) % blk) : a0 + i * inc);
  endtask

  task automatic compare();
    string t_tr, t_ad, t_sb;
    t_tr = !m_active ? "R9" : (m_first ? "R2" : "R3");
    t_ad = m_first ? "R2" : (m_wrap ? "R5" : "R3");
    t_sb = m_wi ? "R8" : "R7";
    if (prev_stall) begin t_tr = "R6"; t_ad = "R6"; t_sb = "R6"; end
    check(t_tr, "htrans", htrans_o, !m_active ? 0 : (m_first ? 2 : 3));
    check("R9", "done", done_o, m_done);
    check("R2", "busy", busy_o, m_active);
    if (m_active) begin
      check(t_ad, "haddr", haddr_o, exp_q[0]);
      check(t_sb, "hwstrb", hwstrb_o, lanes_of(exp_q[0], m_size, m_wi));
      check("R10", "hsize", hsize_o, m_size);
      check("R10", "hburst", hburst_o, m_burst);
    end else begin
      check("R9", "hwstrb idle", hwstrb_o, 0);
    end
  endtask

  task automatic cycle(bit st, bit rdy);
    start_i  = st;
    hready_i = rdy;
    if (htrans_o != 2'b00 && rdy) obs_beats++;
    prev_stall = m_active && !rdy;
    if (m_active) begin
      if (rdy) begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) begin m_active = 0; m_done = 1; end
        else begin m_first = 0; m_done = 0; end
      end else m_done = 0;
    end else begin
      m_done = 0;
      if (st) begin load_model(); m_active = 1; m_first = 1; end
    end
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    compare();
  endtask

  task automatic run_burst(int addr, int sz, int bt, int len, bit wi, bit stall, bit poke);
    int k = 0;
    int n;
    in_addr = addr; in_size = 3'(sz); in_burst = 3'(bt); in_len = 4'(len); in_wi = wi;
    n = beats_of(bt, len);
    obs_beats = 0;
    cycle(1'b1, 1'b1);
    while (m_active) begin
      bit pk = poke && (k == 2);
      if (pk) begin in_addr = 32'h0000_0F00; in_size = 3'd0; in_burst = 3'd0; end
      cycle(pk, stall ? ((k % 3) != 1) : 1'b1);
      k++;
    end
    check("R4", "beat count", obs_beats, n);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "htrans reset", htrans_o, 0);
    check("R1", "hwstrb reset", hwstrb_o, 0);
    check("R1", "busy reset", busy_o, 0);
    check("R1", "done reset", done_o, 0);
    rst_n = 1'b1;
    cycle(1'b0, 1'b1);
    check("R1", "htrans idle after reset", htrans_o, 0);

    run_burst(32'h100, 2, 0, 0, 0, 0, 0);   // single word
    cycle(1'b0, 1'b1);
    run_burst(32'h202, 1, 1, 3, 0, 1, 0);   // incr halfword, stalls
    run_burst(32'h30, 1, 6, 0, 0, 0, 0);    // wrap16 halfword, back-to-back
    run_burst(32'h13, 0, 2, 0, 0, 1, 0);    // wrap4 byte
    cycle(1'b0, 1'b0);
    run_burst(32'h18, 2, 4, 0, 1, 0, 0);    // wrap8 word, word-invariant
    run_burst(32'h41, 0, 3, 0, 1, 1, 0);    // incr4 byte, word-invariant
    run_burst(32'h06, 1, 2, 0, 1, 0, 0);    // wrap4 halfword, word-invariant
    run_burst(32'h33, 1, 5, 0, 0, 0, 0);    // unaligned start, incr8
    run_burst(32'h10, 3, 3, 0, 0, 0, 0);    // oversize size code -> word
    run_burst(32'h80, 1, 7, 0, 0, 1, 1);    // incr16, start raised mid-burst
    run_burst(32'h1FC, 0, 6, 0, 1, 1, 0);   // wrap16 byte, word-invariant
    cycle(1'b0, 1'b1);
    check("R9", "final idle htrans", htrans_o, 0);
    summary();
    $finish;
  end
endmodule